// File: doc/BRIEF.md
# HDLC Channel Event Capture and Interrupt Mask

This block gathers the events of one HDLC serial channel into a 32-bit sticky event register. The transmitter and receiver send it single-cycle pulses and live status levels. Each event bit has its own set condition. Graceful-stop completion waits for the frame that was in flight when the stop was asked for. Receive-frame completion trails the end of the closing flag by a fixed number of clocks. Transmit-buffer completion comes at one of two points, depending on whether the buffer closes the frame. Flag presence and line idle raise an event on every change of their level.

A 32-bit mask register sits beside the event register, and one interrupt line reports any event whose mask bit is set. Software works through a synchronous register port. It reads either register. It writes the mask. It clears event bits by writing ones to the event register. Bits are numbered with 0 as the most significant bit, so big-endian bit n sits at vector index 31-n.

Top module: `hdlc_event_unit`

## Requirements
- R1: After a synchronous active-high reset, the event register and the mask register read zero, and `irq` is low.
- R2: Only these big-endian bits are defined: graceful-stop done at 8 (0x0080_0000), transmit error at 11 (0x0010_0000), receive frame at 12 (0x0008_0000), busy discard at 13 (0x0004_0000), transmit buffer at 14 (0x0002_0000), receive buffer at 15 (0x0001_0000), flag change at 22 (0x0000_0200) and idle change at 23 (0x0000_0100). All other bits of both registers always read zero, and writing ones to them has no effect. `reg_sel`=0 selects the event register and `reg_sel`=1 selects the mask register.
- R3: Event bits are sticky. Writing a one to an event bit clears it on the next clock edge. Writing a zero leaves the bit unchanged.
- R4: If an event's set condition occurs in the same cycle as a write that clears that bit, the bit ends up set.
- R5: `irq` is high exactly when the AND of the event and mask registers is non-zero.
- R6: A graceful-stop command given while no transmit frame is in progress sets bit 8 on the next clock edge.
- R7: A graceful-stop command given while a frame is in progress sets bit 8 only at the edge after that frame's end pulse. It does not set the bit earlier.
- R8: Bit 12 sets exactly RXF_DELAY clock edges after the edge that samples the closing-flag-end pulse. It never sets at the edge right after that pulse. A second closing-flag end that arrives while one is still pending is not lost: it sets bit 12 again RXF_DELAY edges after the first one fires.
- R9: A buffer-written pulse with `tx_buf_is_last`=0 sets bit 14 on the next edge. With `tx_buf_is_last`=1, bit 14 stays clear until the edge that samples `tx_close_final_bit`.
- R10: A CTS-lost pulse or an underrun pulse sets bit 11. A discard for lack of buffers sets bit 13. A partial-frame buffer sets bit 15.
- R11: Bit 22 sets on both the rising and the falling edge of `rx_flags_live`. Bit 23 sets on both edges of `line_idle_live`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the event register, 1 selects the mask register |
| reg_wdata | input | 32 | Write data (ones clear event bits; the mask is written as given) |
| reg_rdata | output | 32 | Read data of the selected register |
| irq | output | 1 | Interrupt request |
| tx_gstop_cmd | input | 1 | Graceful-stop command pulse |
| tx_frame_busy | input | 1 | Level: a transmit frame is in progress |
| tx_frame_end | input | 1 | Pulse: the transmitter finished the current frame |
| tx_buf_loaded | input | 1 | Pulse: the last byte of a buffer was written into the transmit FIFO |
| tx_buf_is_last | input | 1 | Qualifies tx_buf_loaded: the buffer closes the frame |
| tx_close_final_bit | input | 1 | Pulse: the final bit of the closing flag starts to go out |
| tx_cts_lost | input | 1 | Pulse: CTS dropped during transmission |
| tx_underrun | input | 1 | Pulse: the transmit FIFO underran |
| rx_close_flag_end | input | 1 | Pulse: last bit of a closing flag received, frame complete |
| rx_discard_nobuf | input | 1 | Pulse: a received frame was dropped for lack of buffers |
| rx_partial_buf | input | 1 | Pulse: a buffer holding part of a frame was closed |
| rx_flags_live | input | 1 | Level: the receiver currently sees flags |
| line_idle_live | input | 1 | Level: the line is currently idle |

## Verification
The bench builds the block with RXF_DELAY=4 rather than the default 2. This leaves three clear cycles between the closing-flag-end pulse and the receive-frame event. The bench can then confirm that the bit stays low over the whole window and rises on exactly the fourth edge. With that window, a second closing flag can also be injected while the first is still pending. The bench then shows that the second request is reloaded and fires four edges after the first, after software has cleared the bit in between.

// File: rtl/hdlc_evt_pkg.sv
package hdlc_evt_pkg;
  localparam int REG_W = 32;

  // big-endian bit numbers of the defined events
  localparam int BE_GRA = 8;
  localparam int BE_TXE = 11;
  localparam int BE_RXF = 12;
  localparam int BE_BSY = 13;
  localparam int BE_TXB = 14;
  localparam int BE_RXB = 15;
  localparam int BE_FLG = 22;
  localparam int BE_IDL = 23;

  // vector index of a big-endian bit number
  function automatic int be_idx(input int n);
    return REG_W - 1 - n;
  endfunction

  // one-hot mask of a big-endian bit number
  function automatic logic [REG_W-1:0] be_bit(input int n);
    return {{(REG_W-1){1'b0}}, 1'b1} << be_idx(n);
  endfunction

  function automatic logic [REG_W-1:0] defined_bits();
    return be_bit(BE_GRA) | be_bit(BE_TXE) | be_bit(BE_RXF) | be_bit(BE_BSY) |
           be_bit(BE_TXB) | be_bit(BE_RXB) | be_bit(BE_FLG) | be_bit(BE_IDL);
  endfunction

  // sticky update: clear by ones written, set conditions win
  function automatic logic [REG_W-1:0] sticky_next(input logic [REG_W-1:0] cur,
                                                   input logic [REG_W-1:0] setv,
                                                   input logic [REG_W-1:0] clrv);
    return ((cur & ~clrv) | setv) & defined_bits();
  endfunction
endpackage

// File: rtl/hdlc_evt_edge.sv
module hdlc_evt_edge (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic toggled
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  assign toggled = level ^ prev_q;
endmodule

// File: rtl/hdlc_evt_timer.sv
module hdlc_evt_timer #(
  parameter int DELAY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic fire
);
  localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY + 1);
  localparam logic [CW-1:0] RELOAD = CW'(DELAY - 1);

  logic          busy_q;
  logic          again_q;
  logic [CW-1:0] cnt_q;

  assign fire = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      again_q <= 1'b0;
      cnt_q   <= '0;
    end else if (fire) begin
      busy_q  <= again_q | start;
      again_q <= 1'b0;
      cnt_q   <= RELOAD;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
      if (start) again_q <= 1'b1;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= RELOAD;
    end
  end

  generate
    if (DELAY >= 2) begin : g_early
      // R8
      rxf_not_early_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy_q) |=> !fire);
    end
  endgenerate

  // R8
  rxf_pending_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !fire && start) |=> busy_q);
endmodule

// File: rtl/hdlc_evt_gra.sv
module hdlc_evt_gra (
  input  logic clk,
  input  logic rst,
  input  logic stop_cmd,
  input  logic frame_busy,
  input  logic frame_end,
  output logic fire
);
  logic wait_q;

  assign fire = (stop_cmd && (!frame_busy || frame_end)) || (wait_q && frame_end);

  always_ff @(posedge clk) begin
    if (rst)                                      wait_q <= 1'b0;
    else if (frame_end)                           wait_q <= 1'b0;
    else if (stop_cmd && frame_busy)              wait_q <= 1'b1;
  end

  // R7
  gra_deferred_chk: assert property (@(posedge clk) disable iff (rst)
    (wait_q && !frame_end && !stop_cmd) |-> !fire);
endmodule

// File: rtl/hdlc_evt_txb.sv
module hdlc_evt_txb (
  input  logic clk,
  input  logic rst,
  input  logic buf_loaded,
  input  logic buf_last,
  input  logic close_bit,
  output logic fire
);
  logic pend_q;
  logic mid_buf, end_buf;

  assign mid_buf = buf_loaded && !buf_last;
  assign end_buf = buf_loaded && buf_last;
  assign fire    = mid_buf || (close_bit && (pend_q || end_buf));

  always_ff @(posedge clk) begin
    if (rst)            pend_q <= 1'b0;
    else if (close_bit) pend_q <= 1'b0;
    else if (end_buf)   pend_q <= 1'b1;
  end

  // R9
  txb_last_waits_chk: assert property (@(posedge clk) disable iff (rst)
    (end_buf && !close_bit) |-> !fire);
endmodule

// File: rtl/hdlc_event_unit.sv
module hdlc_event_unit
  import hdlc_evt_pkg::*;
#(
  parameter int RXF_DELAY = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  input  logic        tx_gstop_cmd,
  input  logic        tx_frame_busy,
  input  logic        tx_frame_end,
  input  logic        tx_buf_loaded,
  input  logic        tx_buf_is_last,
  input  logic        tx_close_final_bit,
  input  logic        tx_cts_lost,
  input  logic        tx_underrun,
  input  logic        rx_close_flag_end,
  input  logic        rx_discard_nobuf,
  input  logic        rx_partial_buf,
  input  logic        rx_flags_live,
  input  logic        line_idle_live
);
  localparam int NLVL = 2;
  localparam logic [REG_W-1:0] DEF = defined_bits();

  logic [REG_W-1:0] ev_q, mask_q, set_vec, clr_vec;
  logic gra_fire, rxf_fire, txb_fire, txe_fire;
  logic [NLVL-1:0] lvl_in, lvl_edge;

  hdlc_evt_gra u_gra (
    .clk(clk), .rst(rst), .stop_cmd(tx_gstop_cmd), .frame_busy(tx_frame_busy),
    .frame_end(tx_frame_end), .fire(gra_fire));

  hdlc_evt_timer #(.DELAY(RXF_DELAY)) u_rxf (
    .clk(clk), .rst(rst), .start(rx_close_flag_end), .fire(rxf_fire));

  hdlc_evt_txb u_txb (
    .clk(clk), .rst(rst), .buf_loaded(tx_buf_loaded), .buf_last(tx_buf_is_last),
    .close_bit(tx_close_final_bit), .fire(txb_fire));

  assign lvl_in = {line_idle_live, rx_flags_live};

  generate
    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
      hdlc_evt_edge u_edge (.clk(clk), .rst(rst), .level(lvl_in[g]), .toggled(lvl_edge[g]));
    end
  endgenerate

  assign txe_fire = tx_cts_lost || tx_underrun;

  always_comb begin
    set_vec = '0;
    set_vec[be_idx(BE_GRA)] = gra_fire;
    set_vec[be_idx(BE_TXE)] = txe_fire;
    set_vec[be_idx(BE_RXF)] = rxf_fire;
    set_vec[be_idx(BE_BSY)] = rx_discard_nobuf;
    set_vec[be_idx(BE_TXB)] = txb_fire;
    set_vec[be_idx(BE_RXB)] = rx_partial_buf;
    set_vec[be_idx(BE_FLG)] = lvl_edge[0];
    set_vec[be_idx(BE_IDL)] = lvl_edge[1];
  end

  assign clr_vec = (reg_we && !reg_sel) ? reg_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q   <= '0;
      mask_q <= '0;
    end else begin
      ev_q <= sticky_next(ev_q, set_vec, clr_vec);
      if (reg_we && reg_sel) mask_q <= reg_wdata & DEF;
    end
  end

  assign reg_rdata = reg_sel ? mask_q : ev_q;
  assign irq       = |(ev_q & mask_q);

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((ev_q | mask_q) & ~DEF) == '0);
  // R3
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && !reg_sel && set_vec == '0) |=> ((ev_q & $past(reg_wdata)) == '0));
  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ev_q & $past(set_vec)) == $past(set_vec)));
  // R5
  mask_zero_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |-> !irq);
  // R6
  gra_immediate_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_gstop_cmd && !tx_frame_busy) |=> ev_q[be_idx(BE_GRA)]);
  // R10
  txe_set_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_cts_lost || tx_underrun) |=> ev_q[be_idx(BE_TXE)]);
  // R11
  flg_edge_chk: assert property (@(posedge clk) disable iff (rst)
    lvl_edge[0] |=> ev_q[be_idx(BE_FLG)]);
endmodule

// File: tb/hdlc_event_unit_test.sv
`timescale 1ns/1ps
module hdlc_event_unit_test;
  localparam int DLY = 4;
  localparam logic [31:0] B_GRA = 32'h0080_0000, B_TXE = 32'h0010_0000,
    B_RXF = 32'h0008_0000, B_BSY = 32'h0004_0000, B_TXB = 32'h0002_0000,
    B_RXB = 32'h0001_0000, B_FLG = 32'h0000_0200, B_IDL = 32'h0000_0100;
  localparam logic [31:0] ALL = 32'h009F_0300;

  logic clk = 0, rst = 1;
  logic reg_we = 0, reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq;
  logic tx_gstop_cmd = 0, tx_frame_busy = 0, tx_frame_end = 0, tx_buf_loaded = 0;
  logic tx_buf_is_last = 0, tx_close_final_bit = 0, tx_cts_lost = 0, tx_underrun = 0;
  logic rx_close_flag_end = 0, rx_discard_nobuf = 0, rx_partial_buf = 0;
  logic rx_flags_live = 0, line_idle_live = 0;
  int errs = 0, checks = 0;

  always #4 clk = ~clk;

  hdlc_event_unit #(.RXF_DELAY(DLY)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] bebit(input int n);
    return 32'h1 << (31 - n);
  endfunction

  task automatic rd(input logic sel, output logic [31:0] v);
    reg_sel = sel; #1; v = reg_rdata;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_wdata = 0; reg_sel = 0;
  endtask

  task automatic chk_ev(input string req, input logic [31:0] exp);
    logic [31:0] v; rd(0, v); chk(req, v, exp);
  endtask

  task automatic clear_all();
    wr(0, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, v); chk("R1 event", v, 0);
    rd(1, v); chk("R1 mask", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_layout();
    logic [31:0] v;
    chk("R2 bitcalc", bebit(8) | bebit(11) | bebit(12) | bebit(13) | bebit(14) |
        bebit(15) | bebit(22) | bebit(23), ALL);
    wr(1, 32'hFFFF_FFFF);
    rd(1, v); chk("R2 mask reserved", v, ALL);
    wr(1, 0);
  endtask

  task automatic t_w1c();
    rx_discard_nobuf = 1; rx_partial_buf = 1; @(negedge clk);
    rx_discard_nobuf = 0; rx_partial_buf = 0;
    chk_ev("R10 bsy rxb", B_BSY | B_RXB);
    wr(0, 32'h0);
    chk_ev("R3 zero write", B_BSY | B_RXB);
    wr(0, B_BSY);
    chk_ev("R3 one clears", B_RXB);
    clear_all();
  endtask

  task automatic t_set_wins();
    tx_underrun = 1; @(negedge clk); tx_underrun = 0;
    chk_ev("R10 underrun", B_TXE);
    reg_we = 1; reg_sel = 0; reg_wdata = B_TXE; tx_cts_lost = 1;
    @(negedge clk);
    reg_we = 0; reg_wdata = 0; tx_cts_lost = 0;
    chk_ev("R4 set wins", B_TXE);
    clear_all();
  endtask

  task automatic t_irq();
    wr(1, B_TXE);
    rx_partial_buf = 1; @(negedge clk); rx_partial_buf = 0;
    chk("R5 unmasked event", {31'b0, irq}, 0);
    tx_cts_lost = 1; @(negedge clk); tx_cts_lost = 0;
    chk("R5 masked event", {31'b0, irq}, 1);
    wr(0, B_TXE);
    chk("R5 after clear", {31'b0, irq}, 0);
    wr(1, 0); clear_all();
  endtask

  task automatic t_gra();
    tx_gstop_cmd = 1; @(negedge clk); tx_gstop_cmd = 0;
    chk_ev("R6 idle stop", B_GRA);
    clear_all();
    tx_frame_busy = 1;
    tx_gstop_cmd = 1; @(negedge clk); tx_gstop_cmd = 0;
    chk_ev("R7 waits", 0);
    repeat (3) @(negedge clk);
    chk_ev("R7 still waits", 0);
    tx_frame_end = 1; @(negedge clk); tx_frame_end = 0; tx_frame_busy = 0;
    chk_ev("R7 after end", B_GRA);
    clear_all();
  endtask

  task automatic t_rxf();
    rx_close_flag_end = 1; @(negedge clk); rx_close_flag_end = 0;   // n0
    chk_ev("R8 not next edge", 0);
    repeat (DLY - 2) @(negedge clk);                                 // n2
    chk_ev("R8 before delay", 0);
    @(negedge clk);                                                  // n3
    chk_ev("R8 one before", 0);
    @(negedge clk);                                                  // n4
    chk_ev("R8 exact delay", B_RXF);
    clear_all();
    // second request while pending
    rx_close_flag_end = 1; @(negedge clk); rx_close_flag_end = 0;   // n0
    @(negedge clk);                                                  // n1
    rx_close_flag_end = 1; @(negedge clk); rx_close_flag_end = 0;   // n2
    @(negedge clk);                                                  // n3
    chk_ev("R8 first pending", 0);
    @(negedge clk);                                                  // n4
    chk_ev("R8 first fires", B_RXF);
    wr(0, B_RXF);                                                    // n5
    chk_ev("R8 cleared", 0);
    repeat (2) @(negedge clk);                                       // n7
    chk_ev("R8 second pending", 0);
    @(negedge clk);                                                  // n8
    chk_ev("R8 second kept", B_RXF);
    clear_all();
  endtask

  task automatic t_txb();
    tx_buf_loaded = 1; @(negedge clk); tx_buf_loaded = 0;
    chk_ev("R9 mid buffer", B_TXB);
    clear_all();
    tx_buf_loaded = 1; tx_buf_is_last = 1; @(negedge clk);
    tx_buf_loaded = 0; tx_buf_is_last = 0;
    chk_ev("R9 last waits", 0);
    repeat (2) @(negedge clk);
    chk_ev("R9 last still waits", 0);
    tx_close_final_bit = 1; @(negedge clk); tx_close_final_bit = 0;
    chk_ev("R9 closing bit", B_TXB);
    clear_all();
  endtask

  task automatic t_levels();
    rx_flags_live = 1; @(negedge clk);
    chk_ev("R11 flg rise", B_FLG);
    clear_all(); @(negedge clk);
    chk_ev("R11 flg steady", 0);
    rx_flags_live = 0; @(negedge clk);
    chk_ev("R11 flg fall", B_FLG);
    clear_all();
    line_idle_live = 1; @(negedge clk);
    chk_ev("R11 idl rise", B_IDL);
    clear_all();
    line_idle_live = 0; @(negedge clk);
    chk_ev("R11 idl fall", B_IDL);
    clear_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog R1-run actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_layout();
    t_w1c();
    t_set_wins();
    t_irq();
    t_gra();
    t_rxf();
    t_txb();
    t_levels();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule